// File: doc/BRIEF.md
# Period-Register PWM Generator

This block produces a pulse-width-modulated waveform. An 8-bit period timer counts from zero up to a period register value, then wraps. A selectable prescaler and a fixed divide-by-4 phase counter set how fast it counts. A 10-bit duty value sets the high time at the start of each period. The duty value is split into an 8-bit upper part and a 2-bit lower part. The two phase bits act as sub-tick bits below the timer, so the duty comparison has a resolution of one phase step rather than one timer step.

Besides the raw waveform, the block gives two outputs for downstream output logic. One is a single-cycle strobe at every period boundary. The other is a sticky period-complete flag that software or a sequencer clears with an explicit input. Duty writes are held in a shadow copy that is refreshed only at period boundaries, so a change never tears a period in progress. Dropping the enable returns all counters to zero and forces the output low.

Top module: `pwmgen_core`

## Requirements
- R1: One period lasts (period register + 1) × 4 × D system clocks. D is the prescale divisor: select code 0 gives 1, code 1 gives 4, codes 2 and 3 give 16.
- R2: The duty value is the upper part concatenated above the lower part, {duty_hi_i, duty_lo_i}. The output is high for the first duty × D clocks of each period and low for the rest.
- R3: When the duty value is equal to or greater than (period register + 1) × 4, the output is high for the whole period.
- R4: A duty value of zero keeps the output low for the whole period.
- R5: With the period register at FFh, every one of the 1024 duty steps is distinct. For example, duty 513 at divisor 1 gives 513 high clocks out of 1024.
- R6: A duty change made in the middle of a period does not alter that period. It takes effect from the next period boundary.
- R7: boundary_o pulses high for exactly one clock at the start of each period, in the same cycle the new period's first output value appears.
- R8: period_flag_o is set by every period boundary. It stays set, even while disabled, until flag_clr_i is sampled high. A boundary in the same cycle as a clear leaves the flag set.
- R9: While en_i is low, the output is low and no boundary strobes occur. After en_i rises, the first boundary strobe comes exactly one full period later, because the timer restarts from zero.
- R10: After reset, pwm_o, boundary_o and period_flag_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable; low holds counters at zero |
| presc_sel_i | input | 2 | Prescale select: 0 → 1, 1 → 4, 2/3 → 16 |
| period_i | input | 8 | Period register (last timer value of a period) |
| duty_hi_i | input | 8 | Upper eight bits of the duty value |
| duty_lo_i | input | 2 | Lower two bits of the duty value |
| flag_clr_i | input | 1 | Clears the period-complete flag |
| pwm_o | output | 1 | Raw PWM waveform |
| boundary_o | output | 1 | One-cycle strobe at each period start |
| period_flag_o | output | 1 | Sticky period-complete flag |

## Verification
The hardest situations to reach from the ports are the duty write that lands inside a running period and the clear that collides with a boundary. Both depend on exact cycle placement relative to the internal timer. The stimulus finds them by using boundary_o as a timing reference. It waits for the strobe and changes the duty one clock later, then compares the high time of that period with the next one. It also holds the clear input high across a whole period so that the next strobe coincides with it. Exact period lengths and high times are measured by counting clocks between successive strobes, across all three divisors, zero duty, over-range duty and the full 10-bit setting.

// File: rtl/pwmgen_pkg.sv
package pwmgen_pkg;
    // Default widths of the period timer and of the sub-tick phase counter
    localparam int PWM_TMR_W = 8;
    localparam int PWM_SUB_W = 2;
    // Number of prescale choices; choice k divides by 4**k
    localparam int PWM_NSEL  = 3;
    localparam int PWM_SEL_W = 2;
endpackage

// File: rtl/pwmgen_prescale.sv
module pwmgen_prescale
    import pwmgen_pkg::*;
#(
    parameter int NSEL  = PWM_NSEL,
    parameter int SEL_W = PWM_SEL_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             sub_tick_o
);
    localparam int PS_W = 2 * (NSEL - 1);
    localparam logic [SEL_W-1:0] SEL_MAX = SEL_W'(NSEL - 1);

    logic [PS_W-1:0] lim_tab [NSEL];
    logic [PS_W-1:0] cnt_d, cnt_q;
    logic [SEL_W-1:0] sel_eff;
    logic            tick;

    // Terminal count per choice: 4**k - 1
    for (genvar g = 0; g < NSEL; g++) begin : g_lim
        assign lim_tab[g] = PS_W'((1 << (2 * g)) - 1);
    end

    always_comb begin
        sel_eff = (sel_i > SEL_MAX) ? SEL_MAX : sel_i;
        // >= keeps a select change from stranding the counter above its limit
        tick    = en_i && (cnt_q >= lim_tab[sel_eff]);
        cnt_d   = (!en_i || tick) ? '0 : cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    assign sub_tick_o = tick;
endmodule

// File: rtl/pwmgen_timebase.sv
module pwmgen_timebase
    import pwmgen_pkg::*;
#(
    parameter int TMR_W = PWM_TMR_W,
    parameter int SUB_W = PWM_SUB_W
) (
    input  logic                   clk_i,
    input  logic                   rst_ni,
    input  logic                   en_i,
    input  logic                   sub_tick_i,
    input  logic [TMR_W-1:0]       period_i,
    output logic [TMR_W+SUB_W-1:0] fine_nxt_o,
    output logic                   roll_o
);
    typedef struct packed {
        logic [TMR_W-1:0] tmr;
        logic [SUB_W-1:0] ph;
    } tb_t;

    tb_t tb_d, tb_q;
    logic roll;

    always_comb begin
        tb_d = tb_q;
        roll = 1'b0;
        if (!en_i) begin
            tb_d = '0;
        end else if (sub_tick_i) begin
            tb_d.ph = tb_q.ph + 1'b1;
            if (tb_q.ph == '1) begin
                if (tb_q.tmr >= period_i) begin
                    tb_d.tmr = '0;
                    roll     = 1'b1;
                end else begin
                    tb_d.tmr = tb_q.tmr + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) tb_q <= '0;
        else         tb_q <= tb_d;
    end

    // Next fine count: timer above phase, used by the duty comparator
    assign fine_nxt_o = {tb_d.tmr, tb_d.ph};
    assign roll_o     = roll;
endmodule

// File: rtl/pwmgen_duty.sv
module pwmgen_duty
    import pwmgen_pkg::*;
#(
    parameter int DUTY_W = PWM_TMR_W + PWM_SUB_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              en_i,
    input  logic              roll_i,
    input  logic [DUTY_W-1:0] duty_i,
    input  logic [DUTY_W-1:0] fine_nxt_i,
    output logic              pwm_o
);
    typedef struct packed {
        logic [DUTY_W-1:0] shd;
        logic              pwm;
    } dy_t;

    dy_t dy_d, dy_q;

    always_comb begin
        dy_d     = dy_q;
        // Shadow follows the input while idle, latches only at a rollover when running
        dy_d.shd = (!en_i || roll_i) ? duty_i : dy_q.shd;
        dy_d.pwm = en_i && (fine_nxt_i < dy_d.shd);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) dy_q <= '0;
        else         dy_q <= dy_d;
    end

    assign pwm_o = dy_q.pwm;
endmodule

// File: rtl/pwmgen_core.sv
module pwmgen_core
    import pwmgen_pkg::*;
#(
    parameter int TMR_W = PWM_TMR_W,
    parameter int SUB_W = PWM_SUB_W,
    parameter int NSEL  = PWM_NSEL,
    parameter int SEL_W = PWM_SEL_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic [SEL_W-1:0] presc_sel_i,
    input  logic [TMR_W-1:0] period_i,
    input  logic [TMR_W-1:0] duty_hi_i,
    input  logic [SUB_W-1:0] duty_lo_i,
    input  logic             flag_clr_i,
    output logic             pwm_o,
    output logic             boundary_o,
    output logic             period_flag_o
);
    localparam int DUTY_W = TMR_W + SUB_W;

    typedef struct packed {
        logic bnd;
        logic flag;
    } st_t;

    st_t st_d, st_q;
    logic              sub_tick;
    logic              roll;
    logic [DUTY_W-1:0] fine_nxt;

    pwmgen_prescale #(.NSEL(NSEL), .SEL_W(SEL_W)) u_presc (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .en_i       (en_i),
        .sel_i      (presc_sel_i),
        .sub_tick_o (sub_tick)
    );

    pwmgen_timebase #(.TMR_W(TMR_W), .SUB_W(SUB_W)) u_tb (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .en_i       (en_i),
        .sub_tick_i (sub_tick),
        .period_i   (period_i),
        .fine_nxt_o (fine_nxt),
        .roll_o     (roll)
    );

    pwmgen_duty #(.DUTY_W(DUTY_W)) u_duty (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .en_i       (en_i),
        .roll_i     (roll),
        .duty_i     ({duty_hi_i, duty_lo_i}),
        .fine_nxt_i (fine_nxt),
        .pwm_o      (pwm_o)
    );

    always_comb begin
        st_d.bnd  = roll;
        // A rollover wins over a simultaneous clear
        st_d.flag = roll | (st_q.flag & ~flag_clr_i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign boundary_o    = st_q.bnd;
    assign period_flag_o = st_q.flag;
endmodule

// File: rtl/pwmgen_core_chk.sv
module pwmgen_core_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic en_i,
    input logic flag_clr_i,
    input logic pwm_o,
    input logic boundary_o,
    input logic period_flag_o
);
    assert_idle_low_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> !pwm_o);

    assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |=> !boundary_o);

    assert_strobe_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        boundary_o |=> !boundary_o);

    assert_strobe_sets_flag_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        boundary_o |-> period_flag_o);

    assert_flag_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (period_flag_o && !flag_clr_i) |=> period_flag_o);

    assert_flag_clear_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(period_flag_o) |-> $past(flag_clr_i));
endmodule

bind pwmgen_core pwmgen_core_chk u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .en_i          (en_i),
    .flag_clr_i    (flag_clr_i),
    .pwm_o         (pwm_o),
    .boundary_o    (boundary_o),
    .period_flag_o (period_flag_o)
);

// File: tb/pwmgen_core_tb.sv
module pwmgen_core_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic [1:0] sel = '0;
    logic [7:0] per_reg = '0;
    logic [7:0] duty_hi = '0;
    logic [1:0] duty_lo = '0;
    logic       flag_clr = 1'b0;
    logic       pwm_o, boundary_o, period_flag_o;

    int n_chk = 0;
    int n_err = 0;

    always #4 clk = ~clk;

    pwmgen_core u_dut (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .en_i          (en),
        .presc_sel_i   (sel),
        .period_i      (per_reg),
        .duty_hi_i     (duty_hi),
        .duty_lo_i     (duty_lo),
        .flag_clr_i    (flag_clr),
        .pwm_o         (pwm_o),
        .boundary_o    (boundary_o),
        .period_flag_o (period_flag_o)
    );

    // Vectors: select, period reg, duty hi, duty lo, expected period clocks, expected high clocks
    localparam int NV = 9;
    localparam int    V_SEL [NV] = '{0, 1, 2, 0, 0, 0, 0, 1, 0};
    localparam int    V_PER [NV] = '{3, 2, 1, 4, 2, 2, 0, 5, 255};
    localparam int    V_DH  [NV] = '{1, 1, 0, 0, 5, 3, 0, 2, 128};
    localparam int    V_DL  [NV] = '{1, 2, 3, 0, 0, 0, 2, 1, 1};
    localparam int    V_EP  [NV] = '{16, 48, 128, 20, 12, 12, 4, 96, 1024};
    localparam int    V_EH  [NV] = '{5, 24, 48, 0, 12, 12, 2, 36, 513};
    localparam string V_TAG [NV] = '{"R1/R2", "R1/R2", "R1/R2", "R4", "R3", "R3",
                                     "R1/R2", "R1/R2", "R5"};

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Wait for a strobe, then count clocks and high clocks up to the next one
    task automatic measure(output int per, output int hi);
        int guard = 0;
        while (!boundary_o && guard < 5000) begin
            @(negedge clk);
            guard++;
        end
        per = 0;
        hi  = 0;
        do begin
            per++;
            hi += int'(pwm_o);
            @(negedge clk);
        end while (!boundary_o && per < 5000);
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        int per, hi, k, nb;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check("R10 pwm", int'(pwm_o), 0);
        check("R10 boundary", int'(boundary_o), 0);
        check("R10 flag", int'(period_flag_o), 0);

        for (int i = 0; i < NV; i++) begin
            en      = 1'b0;
            sel     = 2'(V_SEL[i]);
            per_reg = 8'(V_PER[i]);
            duty_hi = 8'(V_DH[i]);
            duty_lo = 2'(V_DL[i]);
            repeat (2) @(negedge clk);
            en = 1'b1;
            measure(per, hi);
            check({V_TAG[i], " period"}, per, V_EP[i]);
            check({V_TAG[i], " high"}, hi, V_EH[i]);
        end

        // R6: duty changed one clock into a period applies only from the next one
        en = 1'b0;
        sel = 2'd0; per_reg = 8'd7; duty_hi = 8'd2; duty_lo = 2'd0;
        repeat (2) @(negedge clk);
        en = 1'b1;
        k = 0;
        while (!boundary_o && k < 1000) begin @(negedge clk); k++; end
        hi = int'(pwm_o);
        @(negedge clk);
        duty_hi = 8'd6;
        while (!boundary_o) begin
            hi += int'(pwm_o);
            @(negedge clk);
        end
        check("R6 old duty kept", hi, 8);
        measure(per, hi);
        check("R6 new duty period", per, 32);
        check("R6 new duty high", hi, 24);

        // R9: disabled means low output and no strobes
        en = 1'b0;
        @(negedge clk);
        check("R9 low after disable", int'(pwm_o), 0);
        nb = 0; hi = 0;
        for (int c = 0; c < 100; c++) begin
            nb += int'(boundary_o);
            hi += int'(pwm_o);
            @(negedge clk);
        end
        check("R9 no strobes while idle", nb, 0);
        check("R9 no high while idle", hi, 0);

        // R8: flag held while idle, cleared by the clear input
        check("R8 flag sticky", int'(period_flag_o), 1);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
        check("R8 flag cleared", int'(period_flag_o), 0);

        // R9: first strobe one full period after enable (divisor 4, period reg 2 -> 48)
        sel = 2'd1; per_reg = 8'd2;
        en = 1'b1;
        k = 0;
        while (!boundary_o && k < 1000) begin @(negedge clk); k++; end
        check("R9 restart from zero", k, 48);

        // R7 and R8: strobe lasts one clock; clear held across the next boundary
        flag_clr = 1'b1;
        @(negedge clk);
        check("R7 strobe one clock", int'(boundary_o), 0);
        check("R8 clear while held", int'(period_flag_o), 0);
        k = 0;
        while (!boundary_o && k < 1000) begin @(negedge clk); k++; end
        check("R8 boundary wins over clear", int'(period_flag_o), 1);
        flag_clr = 1'b0;

        finish_run();
    end
endmodule